// File: doc/BRIEF.md
# Serial Boot Mode Loader

The loader runs on the processor side of a power-up configuration link. Cold reset clears it. It then waits until the supply-good input reports a stable core supply, and only then starts a serial read. During the read it drives a slow mode clock, derived from the system clock by a fixed power-of-two divider (256 by default). On each rising edge of that clock it takes one bit from the mode-data input. Bits land in a configuration word starting at bit 0.

When the last bit has been taken, the loader raises a sticky boot-done flag and lets the mode clock finish its current period, then holds it low. The internal core reset stays asserted until the read is complete and cold reset has gone away. It is released one system clock after boot-done rises.

A warm reset asserts the core reset at once and releases it synchronously. It leaves the captured word untouched and does not start a new read. Losing supply-good before the read completes aborts it, and the next read starts again from bit 0. Two fields are decoded from the word and presented only once boot-done is set: a clock-multiplier select and an endianness default.

Top module: `boot_loader`

## Requirements
- R1: While `cold_rst` is high, `mode_clk` is 0, `boot_done` is 0, `core_rst` is 1 and `cfg_word` is all zeros, whatever `supply_ok` and `mode_din` do.
- R2: While a read is running, `mode_clk` has a period of exactly `DIV` system clocks, with `DIV/2` of them high. It is low whenever no read is running, apart from finishing the period that is open when the read ends.
- R3: The k-th bit of the stream (k counted from 0) is stored into `cfg_word[k]`. It is the value of `mode_din` sampled at the system clock edge on which `mode_clk` rises for the (k+1)-th time.
- R4: `boot_done` rises at the same system clock edge as the `NBITS`-th rising edge of `mode_clk`. It then stays high until the next cold reset.
- R5: `core_rst` stays high while `boot_done` is low. It falls one system clock after `boot_done` rises, provided `cold_rst` and `warm_rst` are low.
- R6: Raising `warm_rst` sets `core_rst` high without waiting for a clock edge. After `warm_rst` falls, `core_rst` stays high until the next rising system clock edge. During a warm reset `cfg_word` and `boot_done` are unchanged and `mode_clk` stays low.
- R7: If `supply_ok` falls before `boot_done`, `mode_clk` is low from the next system clock edge onward. When `supply_ok` returns, the stream is read again from its first bit into `cfg_word[0]`.
- R8: After `boot_done`, a drop of `supply_ok` has no effect on `cfg_word`, `boot_done`, `core_rst` or `mode_clk`.
- R9: `mult_sel` equals `cfg_word[MULT_LSB +: MULT_W]` (bits 7:4 by default) and `big_endian` equals `cfg_word[ENDIAN_BIT]` (bit 8 by default). Both are 0 while `boot_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| cold_rst | input | 1 | Power-on reset, active high, asynchronous assert, synchronous release |
| warm_rst | input | 1 | Warm reset request, active high, may assert asynchronously |
| supply_ok | input | 1 | Core supply stable indication; starts the serial read |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Mode clock, system clock divided by DIV |
| boot_done | output | 1 | Configuration word fully read (sticky) |
| core_rst | output | 1 | Internal reset, active high |
| cfg_word | output | NBITS | Captured configuration word, bit 0 first |
| mult_sel | output | MULT_W | Clock-multiplier select field, 0 until boot_done |
| big_endian | output | 1 | Endianness default field, 0 until boot_done |

## Verification
Random 32-bit streams are mixed with all-ones, all-zeros and alternating patterns. The solid patterns expose a stuck or missing capture. The alternating one exposes an off-by-one bit index or a sample taken on the wrong mode-clock phase. Aborted reads are restarted with a different random stream, so any bit left over from the first attempt shows up as a mismatch. The bench counts mode-clock rising edges on its own, which separates an early or late boot-done from a correct one. A warm-reset pulse and a supply drop after completion tell a loader that keeps its word apart from one that restarts or clears it.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_READ = 2'd1,
    LD_DONE = 2'd2
  } ld_state_e;

  // Divider count at which the mode clock is about to rise
  function automatic int unsigned rise_point(input int unsigned div);
    return div / 2 - 1;
  endfunction

  // Index of the final bit of the stream
  function automatic int unsigned last_index(input int unsigned nbits);
    return nbits - 1;
  endfunction

endpackage

// File: rtl/boot_clkdiv.sv
module boot_clkdiv #(
  parameter int unsigned DIV = 256
) (
  input  logic clk,
  input  logic cold_rst,
  input  logic run,
  input  logic clear,
  output logic mode_clk,
  output logic rise_evt,
  output logic busy
);
  import boot_pkg::*;

  localparam int unsigned CW = $clog2(DIV);
  localparam logic [CW-1:0] RISE_AT = CW'(rise_point(DIV));

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge cold_rst) begin
    if (cold_rst)   cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + CW'(1);
  end

  assign mode_clk = cnt_q[CW-1];
  assign rise_evt = run && (cnt_q == RISE_AT);
  assign busy     = |cnt_q;

endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int unsigned NBITS = 256,
  localparam int unsigned IW = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          cold_rst,
  input  logic          supply_ok,
  input  logic          rise_evt,
  input  logic          div_busy,
  output logic          run,
  output logic          sample_evt,
  output logic          abort_evt,
  output logic [IW-1:0] bit_idx,
  output logic          done
);
  import boot_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(last_index(NBITS));

  ld_state_e     st_q, st_d;
  logic [IW-1:0] idx_q;
  logic          last_evt;

  assign abort_evt  = (st_q == LD_READ) && !supply_ok;
  assign sample_evt = (st_q == LD_READ) && supply_ok && rise_evt;
  assign last_evt   = sample_evt && (idx_q == LAST);
  assign run        = ((st_q == LD_READ) && supply_ok) ||
                      ((st_q == LD_DONE) && div_busy);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LD_IDLE: if (supply_ok) st_d = LD_READ;
      LD_READ: begin
        if (abort_evt)     st_d = LD_IDLE;
        else if (last_evt) st_d = LD_DONE;
      end
      LD_DONE: st_d = LD_DONE;
      default: st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge cold_rst) begin
    if (cold_rst) begin
      st_q  <= LD_IDLE;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (abort_evt)       idx_q <= '0;
      else if (last_evt)   idx_q <= '0;
      else if (sample_evt) idx_q <= idx_q + IW'(1);
    end
  end

  assign bit_idx = idx_q;
  assign done    = (st_q == LD_DONE);

endmodule

// File: rtl/boot_capture.sv
module boot_capture #(
  parameter int unsigned NBITS = 256,
  localparam int unsigned IW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             sample_evt,
  input  logic [IW-1:0]    bit_idx,
  input  logic             din,
  output logic [NBITS-1:0] cfg
);

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk or posedge cold_rst) begin
      if (cold_rst)                                b_q <= 1'b0;
      else if (sample_evt && (bit_idx == IW'(i)))  b_q <= din;
    end
    assign cfg[i] = b_q;
  end

endmodule

// File: rtl/boot_rstgen.sv
module boot_rstgen (
  input  logic clk,
  input  logic cold_rst,
  input  logic warm_rst,
  input  logic done,
  output logic core_rst
);

  logic hold_q;

  always_ff @(posedge clk or posedge cold_rst) begin
    if (cold_rst) hold_q <= 1'b1;
    else          hold_q <= !done || warm_rst;
  end

  // warm and cold requests act at once; release waits for a clock edge
  assign core_rst = hold_q | warm_rst | cold_rst;

endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int unsigned DIV        = 256,
  parameter int unsigned NBITS      = 256,
  parameter int unsigned MULT_LSB   = 4,
  parameter int unsigned MULT_W     = 4,
  parameter int unsigned ENDIAN_BIT = 8
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              warm_rst,
  input  logic              supply_ok,
  input  logic              mode_din,
  output logic              mode_clk,
  output logic              boot_done,
  output logic              core_rst,
  output logic [NBITS-1:0]  cfg_word,
  output logic [MULT_W-1:0] mult_sel,
  output logic              big_endian
);

  localparam int unsigned IW = $clog2(NBITS);

  // internal events, named for the bound checker
  logic          run;
  logic          rise_evt;
  logic          div_busy;
  logic          sample_evt;
  logic          abort_evt;
  logic [IW-1:0] bit_idx;

  boot_clkdiv #(.DIV(DIV)) u_div (
    .clk      (clk),
    .cold_rst (cold_rst),
    .run      (run),
    .clear    (abort_evt),
    .mode_clk (mode_clk),
    .rise_evt (rise_evt),
    .busy     (div_busy)
  );

  boot_seq #(.NBITS(NBITS)) u_seq (
    .clk        (clk),
    .cold_rst   (cold_rst),
    .supply_ok  (supply_ok),
    .rise_evt   (rise_evt),
    .div_busy   (div_busy),
    .run        (run),
    .sample_evt (sample_evt),
    .abort_evt  (abort_evt),
    .bit_idx    (bit_idx),
    .done       (boot_done)
  );

  boot_capture #(.NBITS(NBITS)) u_cap (
    .clk        (clk),
    .cold_rst   (cold_rst),
    .sample_evt (sample_evt),
    .bit_idx    (bit_idx),
    .din        (mode_din),
    .cfg        (cfg_word)
  );

  boot_rstgen u_rst (
    .clk      (clk),
    .cold_rst (cold_rst),
    .warm_rst (warm_rst),
    .done     (boot_done),
    .core_rst (core_rst)
  );

  assign mult_sel   = boot_done ? cfg_word[MULT_LSB +: MULT_W] : '0;
  assign big_endian = boot_done && cfg_word[ENDIAN_BIT];

endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
  parameter int unsigned NBITS  = 256,
  parameter int unsigned MULT_W = 4,
  localparam int unsigned IW = $clog2(NBITS)
) (
  input logic              clk,
  input logic              cold_rst,
  input logic              mode_clk,
  input logic              boot_done,
  input logic              core_rst,
  input logic [NBITS-1:0]  cfg_word,
  input logic [MULT_W-1:0] mult_sel,
  input logic              big_endian,
  input logic              sample_evt,
  input logic              abort_evt,
  input logic [IW-1:0]     bit_idx
);

  AST_RST_UNTIL_DONE: assert property (@(posedge clk) disable iff (cold_rst)
    !boot_done |-> core_rst);                                          // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (cold_rst)
    boot_done |=> boot_done);                                          // R4

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (cold_rst)
    boot_done |=> $stable(cfg_word));                                  // R6

  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (cold_rst)
    sample_evt |=> $rose(mode_clk));                                   // R3

  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (cold_rst)
    abort_evt |=> (!mode_clk && (bit_idx == '0)));                     // R7

  AST_FIELDS_GATED: assert property (@(posedge clk) disable iff (cold_rst)
    !boot_done |-> ((mult_sel == '0) && !big_endian));                 // R9

endmodule

bind boot_loader boot_loader_chk #(.NBITS(NBITS), .MULT_W(MULT_W)) u_chk (
  .clk        (clk),
  .cold_rst   (cold_rst),
  .mode_clk   (mode_clk),
  .boot_done  (boot_done),
  .core_rst   (core_rst),
  .cfg_word   (cfg_word),
  .mult_sel   (mult_sel),
  .big_endian (big_endian),
  .sample_evt (sample_evt),
  .abort_evt  (abort_evt),
  .bit_idx    (bit_idx)
);

// File: tb/tb_boot_loader.sv
`timescale 1ns/1ps
module tb_boot_loader;

  localparam int DIV = 8;
  localparam int NB  = 32;
  localparam int MLSB = 4;
  localparam int MW   = 4;
  localparam int EBIT = 8;

  logic clk = 1'b0;
  logic cold_rst = 1'b1;
  logic warm_rst = 1'b0;
  logic supply_ok = 1'b0;
  logic mode_din;
  logic mode_clk, boot_done, core_rst, big_endian;
  logic [NB-1:0] cfg_word;
  logic [MW-1:0] mult_sel;

  int n_cmp = 0;
  int n_bad = 0;

  // stream driver: bench counts mode-clock rises itself
  logic [NB-1:0] cur = '0;
  int rises = 0;
  int base  = 0;
  int rel;
  assign rel = rises - base;
  assign mode_din = (rel >= 0 && rel < NB) ? cur[rel] : 1'b0;

  always @(posedge mode_clk) rises <= rises + 1;

  always #2.5 clk = ~clk;

  boot_loader #(.DIV(DIV), .NBITS(NB), .MULT_LSB(MLSB), .MULT_W(MW),
                .ENDIAN_BIT(EBIT)) dut (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .supply_ok(supply_ok),
    .mode_din(mode_din), .mode_clk(mode_clk), .boot_done(boot_done),
    .core_rst(core_rst), .cfg_word(cfg_word), .mult_sel(mult_sel),
    .big_endian(big_endian)
  );

  function automatic logic [MW-1:0] exp_mult(input logic [NB-1:0] s);
    return MW'((s >> MLSB) & ((1 << MW) - 1));
  endfunction

  function automatic logic exp_endian(input logic [NB-1:0] s);
    return ((s >> EBIT) & 1) != 0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_cold_reset();
    @(negedge clk);
    cold_rst = 1'b1;
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    cold_rst = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!boot_done && cyc < NB * DIV * 4) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_boot(input logic [NB-1:0] s, input bit measure);
    int cyc, prev_rise, nseen, high_cnt;
    bit prev, mid_done;
    do_cold_reset();
    // R1: cold reset clears any earlier word
    chk(cfg_word == '0, "R1 cfg after cold reset", 64'(cfg_word), 0);
    cur = s;
    base = rises;
    @(negedge clk);
    supply_ok = 1'b1;
    cyc = 0; prev = 1'b0; prev_rise = 0; nseen = 0; high_cnt = 0; mid_done = 1'b0;
    while (!boot_done && cyc < NB * DIV * 4) begin
      @(negedge clk);
      cyc++;
      if (mode_clk && !prev) begin
        nseen++;
        if (measure && nseen == 2) begin
          chk(cyc - prev_rise == DIV, "R2 mode_clk period", 64'(cyc - prev_rise), DIV);
          chk(high_cnt == DIV / 2, "R2 mode_clk high time", 64'(high_cnt), DIV / 2);
        end
        prev_rise = cyc;
        high_cnt = 0;
      end
      if (mode_clk) high_cnt++;
      if (!mid_done && nseen == NB / 2) begin
        mid_done = 1'b1;
        chk(core_rst == 1'b1, "R5 core_rst during read", 64'(core_rst), 1);
        chk(mult_sel == '0 && !big_endian, "R9 fields gated before done",
            64'({mult_sel, big_endian}), 0);
      end
      prev = mode_clk;
    end
    chk(boot_done == 1'b1, "R4 boot_done reached", 64'(boot_done), 1);
    chk(rel == NB, "R4 rises at done", 64'(rel), NB);
    chk(mode_clk == 1'b1, "R4 done with last rise", 64'(mode_clk), 1);
    chk(core_rst == 1'b1, "R5 core_rst at done edge", 64'(core_rst), 1);
    chk(cfg_word == s, "R3 captured word", 64'(cfg_word), 64'(s));
    chk(mult_sel == exp_mult(s), "R9 mult_sel", 64'(mult_sel), 64'(exp_mult(s)));
    chk(big_endian == exp_endian(s), "R9 big_endian", 64'(big_endian),
        64'(exp_endian(s)));
    @(negedge clk);
    chk(core_rst == 1'b0, "R5 core_rst released", 64'(core_rst), 0);
  endtask

  task automatic abort_boot(input logic [NB-1:0] s1, input logic [NB-1:0] s2);
    int cyc;
    do_cold_reset();
    cur = s1;
    base = rises;
    @(negedge clk);
    supply_ok = 1'b1;
    while (rel < NB / 2) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    chk(mode_clk == 1'b0, "R7 mode_clk low after abort", 64'(mode_clk), 0);
    chk(boot_done == 1'b0, "R7 not done after abort", 64'(boot_done), 0);
    repeat (2 * DIV) @(negedge clk);
    chk(mode_clk == 1'b0, "R2 mode_clk idle while supply low", 64'(mode_clk), 0);
    cur = s2;
    base = rises;
    supply_ok = 1'b1;
    wait_done(cyc);
    chk(boot_done == 1'b1 && rel == NB, "R7 restart reads full stream",
        64'(rel), NB);
    chk(cfg_word == s2, "R7 word after restart", 64'(cfg_word), 64'(s2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [NB-1:0] s, s2;
    logic [NB-1:0] held;
    int cyc;
    void'($urandom(32'd20917));

    // R1: reset state with supply present and data toggling
    supply_ok = 1'b1;
    cur = '1;
    repeat (4 * DIV) @(negedge clk);
    chk(mode_clk == 1'b0, "R1 mode_clk in reset", 64'(mode_clk), 0);
    chk(boot_done == 1'b0, "R1 boot_done in reset", 64'(boot_done), 0);
    chk(core_rst == 1'b1, "R1 core_rst in reset", 64'(core_rst), 1);
    chk(cfg_word == '0, "R1 cfg in reset", 64'(cfg_word), 0);

    // main boot with random word and period measurement
    s = NB'($urandom());
    run_boot(s, 1'b1);

    // R2: mode clock stays low after completion
    repeat (3 * DIV) @(negedge clk);
    chk(mode_clk == 1'b0, "R2 mode_clk low after done", 64'(mode_clk), 0);
    chk(rel == NB, "R2 no extra rises after done", 64'(rel), NB);

    // R8: supply drop after done is ignored
    held = cfg_word;
    supply_ok = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    chk(cfg_word == held && boot_done, "R8 word kept on supply drop",
        64'(cfg_word), 64'(held));
    chk(!core_rst && !mode_clk, "R8 core_rst/mode_clk unchanged",
        64'({core_rst, mode_clk}), 0);
    supply_ok = 1'b1;

    // R6: warm reset
    @(negedge clk);
    warm_rst = 1'b1;
    #1;
    chk(core_rst == 1'b1, "R6 warm asserts core_rst at once", 64'(core_rst), 1);
    repeat (2 * DIV) @(negedge clk);
    chk(cfg_word == held && boot_done, "R6 word kept in warm reset",
        64'(cfg_word), 64'(held));
    chk(mode_clk == 1'b0 && rel == NB, "R6 no re-read in warm reset",
        64'(rel), NB);
    warm_rst = 1'b0;
    #1;
    chk(core_rst == 1'b1, "R6 release waits for edge", 64'(core_rst), 1);
    @(negedge clk);
    chk(core_rst == 1'b0, "R6 core_rst released", 64'(core_rst), 0);

    // directed patterns
    run_boot('1, 1'b0);
    run_boot({(NB/2){2'b10}}, 1'b0);
    run_boot({(NB/2){2'b01}}, 1'b0);
    run_boot('0, 1'b0);

    // R7: aborted reads
    abort_boot('1, NB'($urandom()));
    abort_boot(NB'($urandom()), {(NB/2){2'b01}});

    // more random words
    for (int i = 0; i < 3; i++) begin
      s2 = NB'($urandom());
      run_boot(s2, i == 0);
    end

    wait_done(cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule